// File: doc/BRIEF.md
# Exception status and cause unit

This block keeps the exception-state registers of a small multicycle processor. These are a status word, a cause word, the saved exception PC (EPC), and the fixed address of the exception handler. The controller gives it the current PC, two synchronous trap requests (undefined instruction and arithmetic overflow), five level-sensitive hardware interrupt lines, a return-from-exception strobe and a software write port for the status word. When the block accepts an exception, it raises a take pulse in that same cycle and presents the handler address for the PC redirect. On the next clock edge it stores PC minus 4 into EPC, records the cause code and pushes the kernel/enable stack of the status word.

The status word holds an 8-bit interrupt mask in bits 15:8 and a three-level stack of (user-mode, interrupt-enable) pairs in bits 5:0. The current pair is in bits 1:0, the previous pair in bits 3:2 and the oldest pair in bits 5:4. For each pair, the user bit (upper bit of the pair) is 1 for user mode and the enable bit (lower bit of the pair) is 1 for interrupts enabled. Hardware interrupt line i is latched as pending in cause bit 10+i. Its mask bit is status bit 10+i. The remaining mask bits 8, 9 and 15 belong to software levels and are only stored.

Top module: `exc_status_unit`

## Requirements
- R1: After a synchronous active-low reset, status, cause and EPC read zero and take_exc is 0 while no request is present.
- R2: An undefined-instruction request is accepted in the same cycle: take_exc is 1 and redirect_pc is 0x80000080. After the edge, cause bits 5:2 hold 10 and EPC holds pc_cur minus 4, modulo 2^32.
- R3: An overflow request alone is accepted the same way and writes code 12 to cause bits 5:2.
- R4: When requests coincide, undefined instruction beats overflow, and overflow beats an external interrupt. The code written belongs to the winner, and a pending bit is not cleared when a trap wins.
- R5: On acceptance, status bits 5:0 become the old bits 3:0 followed by 00, and mask bits 15:8 are unchanged.
- R6: A return strobe with no exception and no software write sets status bits 5:0 to {old[5:4], old[5:2]}. This puts the previous pair back in the current place and keeps the oldest pair. No exception is taken.
- R7: A high interrupt line i sets cause bit 10+i from the next cycle on. The bit stays set after the line falls, regardless of the enable and mask bits, until it is serviced.
- R8: An external interrupt is taken, with code 0, only when status bit 0 is 1 and some pending bit 10+i has its status mask bit 10+i set.
- R9: Taking an external interrupt clears only the lowest-numbered pending bit that was both pending and unmasked. Other pending bits stay set.
- R10: A software write loads status bits 15:8 and 5:0 from the data, and bits 7:6 always read 0. An accepted exception in the same cycle discards the write. A write beats a simultaneous return strobe.
- R11: With no accepted exception, take_exc is 0 and EPC and the cause code keep their values. Cause bits 31:16, 15, 9:6 and 1:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_cur | input | 32 | PC value the controller holds this cycle (already advanced by 4) |
| req_undef | input | 1 | Undefined-instruction trap request |
| req_ovf | input | 1 | Arithmetic-overflow trap request |
| irq_hw | input | 5 | Hardware interrupt lines, level sensitive |
| rfe_strobe | input | 1 | Return-from-exception: pop the status stack |
| sts_wr_en | input | 1 | Software write enable for the status word |
| sts_wr_data | input | 16 | Software write data for the status word |
| status_q | output | 32 | Status word, zero-extended |
| cause_q | output | 32 | Cause word: pending bits and exception code |
| epc_q | output | 32 | Saved return address |
| redirect_pc | output | 32 | Handler entry address, used when take_exc is 1 |
| take_exc | output | 1 | High in the cycle an exception is accepted |

## Verification
The bench sweeps all 64 stack patterns in status bits 5:0 against every trap, return and write combination, and checks the exact push and pop bit movement. A design that shifts the stack the wrong way would corrupt the oldest pair on return, and one that zeroed the wrong end would leave kernel mode with interrupts still enabled. The interrupt sweep covers every mask pattern, every line and both enable states. It shows that pending bits are latched even while masked or disabled, and that a masked line never fires. It also covers coincident requests, where a design with the priorities inverted would record the wrong code or clear a pending bit that the handler never saw. The PC-zero case catches an EPC rewind that saturates instead of wrapping.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception status and cause unit.
// Assumes a 32-bit machine word and a 16-bit architectural status field.
package exc_pkg;
    localparam int unsigned STS_W     = 16;  // implemented status bits
    localparam int unsigned STACK_W   = 6;   // three (user, enable) pairs
    localparam int unsigned CODE_W    = 4;   // exception code width
    localparam int unsigned CODE_LSB  = 2;   // code lives in cause[5:2]
    localparam int unsigned PEND_LSB  = 10;  // pending bits start at cause[10]
    localparam int unsigned PEND_MAX  = 6;   // cause[15:10]
    localparam int unsigned MASK_LSB  = 8;   // mask occupies status[15:8]

    localparam logic [CODE_W-1:0] CODE_EXT_INT = 4'd0;
    localparam logic [CODE_W-1:0] CODE_UNDEF   = 4'd10;
    localparam logic [CODE_W-1:0] CODE_OVF     = 4'd12;

    // Bits of the status word that software may load (7:6 stay zero).
    localparam logic [STS_W-1:0] STS_WR_MASK = 16'hFF3F;

    // Outcome of the request arbitration in one cycle.
    typedef struct packed {
        logic              take;
        logic              is_int;
        logic [CODE_W-1:0] code;
    } exc_decision_t;
endpackage

// File: rtl/exc_irq_pending.sv
// Pending-interrupt latch and service selector.
// Each hardware line sets its pending bit while high; the bit holds until the
// interrupt it stands for is serviced. Service clears the lowest-numbered bit
// that is both pending and unmasked. Assumes level-sensitive, synchronous lines.
module exc_irq_pending #(
    parameter int unsigned NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_hw,
    input  logic [NUM_IRQ-1:0] mask_hw,
    input  logic               glob_ie,
    input  logic               svc,
    output logic [NUM_IRQ-1:0] pending,
    output logic               int_req
);
    logic [NUM_IRQ-1:0] elig;
    logic [NUM_IRQ-1:0] lowest;
    logic [NUM_IRQ-1:0] clr;

    // Eligible lines and the lowest-numbered one among them.
    always_comb begin
        elig    = pending & mask_hw;
        lowest  = elig & (~elig + NUM_IRQ'(1));
        int_req = glob_ie & (|elig);
        clr     = svc ? lowest : '0;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        // Latch line i; service clears it unless the line is still high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
            end else begin
                pending[i] <= (pending[i] & ~clr[i]) | irq_hw[i];
            end
        end
    end
endmodule

// File: rtl/exc_prio_sel.sv
// Fixed-priority arbitration of exception requests.
// Order: undefined instruction, then overflow, then external interrupt.
// Purely combinational; the interrupt request arrives already qualified.
module exc_prio_sel
    import exc_pkg::*;
(
    input  logic          req_undef,
    input  logic          req_ovf,
    input  logic          int_req,
    output exc_decision_t dec
);
    // Pick the winning source and its code.
    always_comb begin
        dec = '{take: 1'b0, is_int: 1'b0, code: CODE_EXT_INT};
        if (req_undef) begin
            dec.take = 1'b1;
            dec.code = CODE_UNDEF;
        end else if (req_ovf) begin
            dec.take = 1'b1;
            dec.code = CODE_OVF;
        end else if (int_req) begin
            dec.take   = 1'b1;
            dec.is_int = 1'b1;
            dec.code   = CODE_EXT_INT;
        end
    end
endmodule

// File: rtl/exc_status_stack.sv
// Status word with the three-level (user, enable) stack in its low bits.
// Update priority: exception push, then software write, then return pop.
// Bits outside STS_WR_MASK are held at zero.
module exc_status_stack
    import exc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] sts
);
    logic [STS_W-1:0] sts_n;

    // Next status value from the highest-priority action.
    always_comb begin
        sts_n = sts;
        if (push) begin
            sts_n[STACK_W-1:0] = {sts[STACK_W-3:0], 2'b00};
        end else if (wr_en) begin
            sts_n = wr_data & STS_WR_MASK;
        end else if (pop) begin
            sts_n[STACK_W-1:0] = {sts[STACK_W-1 -: 2], sts[STACK_W-1:2]};
        end
    end

    // Status register with synchronous reset to kernel mode, disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= sts_n;
        end
    end
endmodule

// File: rtl/exc_status_unit.sv
// Exception status and cause unit (top).
// Accepts traps and interrupts, saves PC - PC_STEP into EPC, records the cause
// code, pushes the status stack and presents the handler address. Assumes
// pc_cur has already been advanced past the faulting instruction, and that
// NUM_HW_IRQ fits in the six cause pending positions.
module exc_status_unit
    import exc_pkg::*;
#(
    parameter int unsigned     XLEN        = 32,
    parameter int unsigned     NUM_HW_IRQ  = 5,
    parameter int unsigned     PC_STEP     = 4,
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0080
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [XLEN-1:0]       pc_cur,
    input  logic                  req_undef,
    input  logic                  req_ovf,
    input  logic [NUM_HW_IRQ-1:0] irq_hw,
    input  logic                  rfe_strobe,
    input  logic                  sts_wr_en,
    input  logic [STS_W-1:0]      sts_wr_data,
    output logic [XLEN-1:0]       status_q,
    output logic [XLEN-1:0]       cause_q,
    output logic [XLEN-1:0]       epc_q,
    output logic [XLEN-1:0]       redirect_pc,
    output logic                  take_exc
);
    localparam logic [XLEN-1:0] PC_REWIND = XLEN'(PC_STEP);

    logic [STS_W-1:0]      sts;
    logic [NUM_HW_IRQ-1:0] pending;
    logic                  int_req;
    exc_decision_t         dec;
    logic [CODE_W-1:0]     code_q;

    exc_irq_pending #(.NUM_IRQ(NUM_HW_IRQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_hw  (irq_hw),
        .mask_hw (sts[PEND_LSB +: NUM_HW_IRQ]),
        .glob_ie (sts[0]),
        .svc     (dec.is_int),
        .pending (pending),
        .int_req (int_req)
    );

    exc_prio_sel u_prio (
        .req_undef (req_undef),
        .req_ovf   (req_ovf),
        .int_req   (int_req),
        .dec       (dec)
    );

    exc_status_stack u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (dec.take),
        .pop     (rfe_strobe),
        .wr_en   (sts_wr_en),
        .wr_data (sts_wr_data),
        .sts     (sts)
    );

    // Capture return address and cause code on an accepted exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q  <= '0;
            code_q <= '0;
        end else if (dec.take) begin
            epc_q  <= pc_cur - PC_REWIND;
            code_q <= dec.code;
        end
    end

    // Assemble the visible words.
    always_comb begin
        status_q                          = '0;
        status_q[STS_W-1:0]               = sts;
        cause_q                           = '0;
        cause_q[CODE_LSB +: CODE_W]       = code_q;
        cause_q[PEND_LSB +: NUM_HW_IRQ]   = pending;
        take_exc                          = dec.take;
        redirect_pc                       = HANDLER_VEC;
    end
endmodule

// File: rtl/exc_status_checker.sv
// Property checker for exc_status_unit, attached with bind below.
module exc_status_checker
    import exc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned NUM_HW_IRQ = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [XLEN-1:0]       pc_cur,
    input logic                  req_undef,
    input logic                  req_ovf,
    input logic [NUM_HW_IRQ-1:0] irq_hw,
    input logic                  rfe_strobe,
    input logic                  sts_wr_en,
    input logic [XLEN-1:0]       status_q,
    input logic [XLEN-1:0]       cause_q,
    input logic [XLEN-1:0]       epc_q,
    input logic                  take_exc
);
    assert_epc_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> epc_q == $past(pc_cur) - XLEN'(4));

    assert_undef_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_undef |-> take_exc);

    assert_ovf_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ovf && !req_undef) |=> cause_q[CODE_LSB +: CODE_W] == CODE_OVF);

    assert_undef_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_undef |=> cause_q[CODE_LSB +: CODE_W] == CODE_UNDEF);

    assert_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00})
                  && (status_q[15:8] == $past(status_q[15:8])));

    assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe_strobe && !take_exc && !sts_wr_en) |=>
            status_q[5:0] == {$past(status_q[5:4]), $past(status_q[5:2])});

    assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hw != '0) |=>
            ((cause_q[PEND_LSB +: NUM_HW_IRQ] & $past(irq_hw)) == $past(irq_hw)));

    assert_int_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && !req_undef && !req_ovf) |->
            (status_q[0] && ((cause_q[PEND_LSB +: NUM_HW_IRQ]
                              & status_q[PEND_LSB +: NUM_HW_IRQ]) != '0)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_exc |=> $stable(epc_q) && $stable(cause_q[CODE_LSB +: CODE_W]));

    assert_cause_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[31:16] == '0) && (cause_q[9:6] == '0) && (cause_q[1:0] == '0));

    assert_status_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[7:6] == 2'b00);
endmodule

bind exc_status_unit exc_status_checker #(
    .XLEN       (XLEN),
    .NUM_HW_IRQ (NUM_HW_IRQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_cur     (pc_cur),
    .req_undef  (req_undef),
    .req_ovf    (req_ovf),
    .irq_hw     (irq_hw),
    .rfe_strobe (rfe_strobe),
    .sts_wr_en  (sts_wr_en),
    .status_q   (status_q),
    .cause_q    (cause_q),
    .epc_q      (epc_q),
    .take_exc   (take_exc)
);

// File: tb/sim_exc_status_unit.sv
// Sweep bench for exc_status_unit: inputs change at the falling edge,
// registered results are read at the following falling edge.
module sim_exc_status_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_cur;
    logic        req_undef, req_ovf, rfe_strobe, sts_wr_en;
    logic [4:0]  irq_hw;
    logic [15:0] sts_wr_data;
    logic [31:0] status_q, cause_q, epc_q, redirect_pc;
    logic        take_exc;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    exc_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .req_undef(req_undef),
        .req_ovf(req_ovf), .irq_hw(irq_hw), .rfe_strobe(rfe_strobe),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .status_q(status_q),
        .cause_q(cause_q), .epc_q(epc_q), .redirect_pc(redirect_pc),
        .take_exc(take_exc)
    );

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_undef = 0; req_ovf = 0; rfe_strobe = 0; sts_wr_en = 0;
        irq_hw = '0; sts_wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; idle(); pc_cur = 32'h400;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic sw_write(input logic [15:0] d);
        sts_wr_en = 1; sts_wr_data = d;
        tick();
        sts_wr_en = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] last_epc;
        logic [3:0]  last_code;
        rst_n = 0; idle(); pc_cur = '0;
        @(negedge clk);
        do_reset();
        // R1: reset state
        eq("R1 status", status_q, 32'h0);
        eq("R1 cause", cause_q, 32'h0);
        eq("R1 epc", epc_q, 32'h0);
        eq("R1 take", {31'b0, take_exc}, 32'h0);

        // R10: bits 7:6 of status always read zero
        sw_write(16'hFFFF);
        eq("R10 gap bits", status_q, 32'h0000_FF3F);

        // Stack sweep: every low pattern against trap / return / write mixes
        last_epc = epc_q; last_code = cause_q[5:2];
        for (int s = 0; s < 64; s++) begin
            for (int kind = 0; kind < 6; kind++) begin
                logic [15:0] d, d2, exp_sts;
                logic [31:0] pc;
                bit          tk;
                d  = 16'hA500 | 16'(s);
                d2 = 16'h5A00 | 16'(63 - s);
                sw_write(d);
                eq("R10 write", status_q, {16'h0, d});
                pc = 32'h0000_2000 + 32'(s * 32) + 32'(kind * 4);
                pc_cur = pc;
                case (kind)
                    0: req_undef = 1;
                    1: req_ovf = 1;
                    2: begin req_undef = 1; req_ovf = 1; end
                    3: rfe_strobe = 1;
                    4: begin req_undef = 1; sts_wr_en = 1; sts_wr_data = d2; end
                    default: begin rfe_strobe = 1; sts_wr_en = 1; sts_wr_data = d2; end
                endcase
                tk = (kind != 3) && (kind != 5);
                #1;
                eq("R11 take flag", {31'b0, take_exc}, {31'b0, tk});
                if (tk) eq("R2 redirect", redirect_pc, 32'h8000_0080);
                tick();
                idle();
                if (tk) begin
                    exp_sts = {8'hA5, 2'b00, d[3:0], 2'b00};
                    last_epc = pc - 32'd4;
                    last_code = (kind == 1) ? 4'd12 : 4'd10;
                end else if (kind == 3) begin
                    exp_sts = {8'hA5, 2'b00, d[5:4], d[5:2]};
                end else begin
                    exp_sts = d2;
                end
                eq((kind == 3) ? "R6 pop" : (kind == 5) ? "R10 write beats return" :
                   (kind == 4) ? "R10 write discarded" : "R5 push",
                   status_q, {16'h0, exp_sts});
                eq((kind == 1) ? "R3 code" : (kind == 2) ? "R4 code" : "R2 code",
                   {28'h0, cause_q[5:2]}, {28'h0, last_code});
                eq("R2 epc", epc_q, last_epc);
                eq("R11 cause zeros", cause_q & 32'hFFFF_83C3, 32'h0);
            end
        end

        // R2: EPC rewind wraps at PC zero
        pc_cur = 32'h0; req_undef = 1; tick(); idle();
        eq("R2 epc wrap", epc_q, 32'hFFFF_FFFC);

        // Interrupt sweep: every mask, line and enable
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 32; m++) begin
                for (int i = 0; i < 5; i++) begin
                    logic [15:0] d;
                    bit          exp_take;
                    do_reset();
                    req_ovf = 1; tick(); idle();      // preload code 12
                    d = (16'(m) << 10) | ((ie != 0) ? 16'h000D : 16'h000C);
                    sw_write(d);
                    irq_hw = 5'(1 << i);
                    #1;
                    eq("R8 no take before latch", {31'b0, take_exc}, 32'h0);
                    tick();
                    irq_hw = '0;
                    eq("R7 pending set", {26'h0, cause_q[15:10]}, 32'(1 << i));
                    exp_take = (ie != 0) && (((m >> i) & 1) != 0);
                    eq("R8 take", {31'b0, take_exc}, {31'b0, exp_take});
                    tick();
                    if (exp_take) begin
                        eq("R9 pending cleared", {26'h0, cause_q[15:10]}, 32'h0);
                        eq("R8 code", {28'h0, cause_q[5:2]}, 32'h0);
                        eq("R5 push on int", status_q, {16'h0, d[15:8], 2'b00, d[3:0], 2'b00});
                        eq("R2 epc int", epc_q, 32'h3FC);
                    end else begin
                        eq("R7 pending held", {26'h0, cause_q[15:10]}, 32'(1 << i));
                        eq("R11 code held", {28'h0, cause_q[5:2]}, 32'd12);
                        eq("R11 no take", {31'b0, take_exc}, 32'h0);
                    end
                end
            end
        end

        // R9: two eligible lines, lowest serviced first
        do_reset();
        sw_write(16'h2801);
        irq_hw = 5'b01010; tick(); idle();
        eq("R9 take", {31'b0, take_exc}, 32'h1);
        tick();
        eq("R9 lowest cleared", {26'h0, cause_q[15:10]}, 32'h08);

        // R4: overflow beats a ready interrupt, pending kept
        do_reset();
        sw_write(16'h0401);
        irq_hw = 5'b00001; tick(); idle();
        req_ovf = 1; tick(); idle();
        eq("R4 ovf over int code", {28'h0, cause_q[5:2]}, 32'd12);
        eq("R4 pending kept", {26'h0, cause_q[15:10]}, 32'h01);

        // R4: all three together, undefined wins
        do_reset();
        sw_write(16'h0401);
        irq_hw = 5'b00001; tick(); idle();
        req_ovf = 1; req_undef = 1; tick(); idle();
        eq("R4 undef over all", {28'h0, cause_q[5:2]}, 32'd10);
        eq("R4 pending kept 2", {26'h0, cause_q[15:10]}, 32'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule